// File: doc/BRIEF.md
# Sensor Register Access Port with Debug-Side Lock

This block is the single way into the 128-entry, 16-bit register file of a sensor-monitor subsystem. Two masters share it. The first is a fabric-side port with enable, write enable, address and data. The second is a command interface fed from the JTAG side. It carries a 4-bit operation code, and a lock input lets it take the register file for itself. Both masters go through one transaction engine. Every accepted access completes a fixed number of clock cycles after it is accepted, and a one-cycle ready strobe marks completion. The read data is presented with that strobe.

Addresses 43h to 47h are a reserved window: they read as zero and writes to them have no effect. Register 41h carries a two-bit acquisition-mode field. Any write that changes that field raises a one-cycle reset pulse toward the acquisition logic. While the lock is held, the fabric port still receives a ready strobe for each request, but the request reads zero data and cannot write.

Top module: `sensor_reg_port`

## Requirements
- R1: After reset every register reads 0000h, both ready strobes and the acquisition reset are low, and both data outputs are 0000h.
- R2: A fabric read accepted at clock edge k (enable high, engine idle) drives the addressed register onto the fabric data output together with a fabric ready pulse at edge k+3.
- R3: A fabric write accepted at edge k updates the register at edge k+3, which is also when the fabric ready pulse appears, with the fabric data output at 0000h. Later reads return the full 16-bit value.
- R4: Each accepted transaction gives exactly one ready pulse, one cycle wide, on the side that issued it.
- R5: A request from either side that arrives on any of the three edges after an acceptance is dropped. It gives no ready pulse and writes nothing.
- R6: While the lock input is high, a fabric request still completes with a fabric ready pulse at edge k+3, with the data output at 0000h, and it leaves the register file unchanged.
- R7: A JTAG command takes effect when its valid input is high. Code 1 is a read and code 2 is a write, each completing with a JTAG ready pulse at edge k+3. Code 0 is a no-operation, and every code from 3 to 15 is ignored: no ready pulse and no write.
- R8: The JTAG data output holds the result of the last completed JTAG read until the next JTAG read completes. Fabric traffic and JTAG writes leave it unchanged.
- R9: When both sides request on the same edge, the fabric wins if the lock is low and the JTAG command wins if the lock is high. The losing request is dropped.
- R10: Addresses 43h, 44h, 45h, 46h and 47h always read 0000h, and writes to them complete with a ready pulse but store nothing. Address 48h is an ordinary register.
- R11: A write to address 41h that changes bits 13:12 pulses the acquisition reset output high for one cycle, in the same cycle as the ready pulse. A write that leaves bits 13:12 unchanged gives no pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fab_en | input | 1 | Fabric request enable |
| fab_we | input | 1 | Fabric write enable, qualifies fab_en |
| fab_addr | input | 7 | Fabric register address |
| fab_wdata | input | 16 | Fabric write data |
| fab_rdata | output | 16 | Fabric read data, valid with fab_rdy |
| fab_rdy | output | 1 | Fabric completion strobe |
| jtag_lock | input | 1 | JTAG side holds exclusive ownership |
| jtag_vld | input | 1 | JTAG command valid |
| jtag_cmd | input | 4 | JTAG operation code (0 nop, 1 read, 2 write) |
| jtag_addr | input | 7 | JTAG register address |
| jtag_wdata | input | 16 | JTAG write data |
| jtag_rdata | output | 16 | Last JTAG read result |
| jtag_rdy | output | 1 | JTAG completion strobe |
| acq_rst | output | 1 | One-cycle reset pulse to the acquisition logic |

## Verification
A stuck or miscounted latency counter shows up at once: the ready strobe arrives on the wrong edge, arrives twice, or does not arrive at all. A wrongly captured owner or blocked flag sends the strobe to the wrong side, or lets a locked fabric write reach storage. That second fault only shows on the next read of that address, so every write scenario is followed by a read-back. A wrong snapshot of the mode field shows as a missing or extra acquisition reset in the completion cycle of the write.

// File: rtl/srp_pkg.sv
package srp_pkg;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 7;
  localparam int CMD_W  = 4;

  typedef enum logic [CMD_W-1:0] {
    JOP_NOP   = 4'd0,
    JOP_READ  = 4'd1,
    JOP_WRITE = 4'd2
  } jop_e;

  // one captured access, whichever side issued it
  typedef struct packed {
    logic              we;
    logic              from_jtag;
    logic              blocked;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] wdata;
  } access_t;
endpackage

// File: rtl/srp_rst_sync.sv
module srp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/srp_arb.sv
module srp_arb
  import srp_pkg::*;
(
  input  logic              busy,
  input  logic              lock,
  input  logic              fab_en,
  input  logic              fab_we,
  input  logic [ADDR_W-1:0] fab_addr,
  input  logic [DATA_W-1:0] fab_wdata,
  input  logic              jtag_vld,
  input  logic [CMD_W-1:0]  jtag_cmd,
  input  logic [ADDR_W-1:0] jtag_addr,
  input  logic [DATA_W-1:0] jtag_wdata,
  output logic              take,
  output access_t           grant
);
  logic    jtag_req;
  access_t fab_acc;
  access_t jtag_acc;

  // only the read and write codes form a request; nop and undefined codes drop out here
  assign jtag_req = jtag_vld &&
                    ((jtag_cmd == JOP_READ) || (jtag_cmd == JOP_WRITE));

  always_comb begin
    fab_acc.we        = fab_we;
    fab_acc.from_jtag = 1'b0;
    fab_acc.blocked   = lock;
    fab_acc.addr      = fab_addr;
    fab_acc.wdata     = fab_wdata;

    jtag_acc.we        = (jtag_cmd == JOP_WRITE);
    jtag_acc.from_jtag = 1'b1;
    jtag_acc.blocked   = 1'b0;
    jtag_acc.addr      = jtag_addr;
    jtag_acc.wdata     = jtag_wdata;
  end

  always_comb begin
    take  = 1'b0;
    grant = fab_acc;
    if (!busy) begin
      if (lock) begin
        if (jtag_req) begin
          take  = 1'b1;
          grant = jtag_acc;
        end else if (fab_en) begin
          take  = 1'b1;
          grant = fab_acc;
        end
      end else begin
        if (fab_en) begin
          take  = 1'b1;
          grant = fab_acc;
        end else if (jtag_req) begin
          take  = 1'b1;
          grant = jtag_acc;
        end
      end
    end
  end
endmodule

// File: rtl/srp_txn_ctrl.sv
module srp_txn_ctrl
  import srp_pkg::*;
#(
  parameter int LATENCY = 3
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    take,
  input  access_t grant,
  output logic    busy,
  output logic    fire,
  output access_t held
);
  localparam int               CNT_W   = $clog2(LATENCY + 1);
  localparam logic [CNT_W-1:0] LAST    = CNT_W'(LATENCY);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic             pend_q, pend_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  access_t          held_q, held_d;
  logic             held_en;

  assign fire    = pend_q && (cnt_q == LAST);
  assign held_en = take;

  always_comb begin
    pend_d = pend_q;
    cnt_d  = cnt_q;
    held_d = held_q;
    if (take) begin
      pend_d = 1'b1;
      cnt_d  = CNT_ONE;
      held_d = grant;
    end else if (fire) begin
      pend_d = 1'b0;
      cnt_d  = '0;
    end else if (pend_q) begin
      cnt_d  = cnt_q + CNT_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      pend_q <= pend_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       held_q <= '0;
    else if (held_en) held_q <= held_d;
  end

  assign busy = pend_q;
  assign held = held_q;
endmodule

// File: rtl/srp_regfile.sv
module srp_regfile
  import srp_pkg::*;
#(
  parameter int                DEPTH     = 128,
  parameter logic [ADDR_W-1:0] RSV_LO    = 7'h43,
  parameter logic [ADDR_W-1:0] RSV_HI    = 7'h47,
  parameter logic [ADDR_W-1:0] MODE_ADDR = 7'h41,
  parameter int                MODE_LO   = 12,
  parameter int                MODE_W    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              acq_rst
);
  localparam int MODE_HI = MODE_LO + MODE_W - 1;

  logic [DEPTH-1:0][DATA_W-1:0] regs;
  logic [MODE_W-1:0] mode_now;
  logic [MODE_W-1:0] mode_new;
  logic              acq_q, acq_d;

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
    if ((gi >= int'(RSV_LO)) && (gi <= int'(RSV_HI))) begin : g_rsv
      assign regs[gi] = '0;
    end else begin : g_reg
      logic [DATA_W-1:0] val_q;
      logic              val_en;
      assign val_en = wr_en && (addr == ADDR_W'(gi));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      val_q <= '0;
        else if (val_en) val_q <= wr_data;
      end
      assign regs[gi] = val_q;
    end
  end

  assign rd_data  = regs[addr];
  assign mode_now = regs[MODE_ADDR][MODE_HI:MODE_LO];
  assign mode_new = wr_data[MODE_HI:MODE_LO];

  always_comb begin
    acq_d = wr_en && (addr == MODE_ADDR) && (mode_new != mode_now);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acq_q <= 1'b0;
    else        acq_q <= acq_d;
  end

  assign acq_rst = acq_q;
endmodule

// File: rtl/sensor_reg_port.sv
module sensor_reg_port
  import srp_pkg::*;
#(
  parameter int                LATENCY   = 3,
  parameter int                DEPTH     = 128,
  parameter logic [ADDR_W-1:0] RSV_LO    = 7'h43,
  parameter logic [ADDR_W-1:0] RSV_HI    = 7'h47,
  parameter logic [ADDR_W-1:0] MODE_ADDR = 7'h41,
  parameter int                MODE_LO   = 12,
  parameter int                MODE_W    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fab_en,
  input  logic              fab_we,
  input  logic [ADDR_W-1:0] fab_addr,
  input  logic [DATA_W-1:0] fab_wdata,
  output logic [DATA_W-1:0] fab_rdata,
  output logic              fab_rdy,
  input  logic              jtag_lock,
  input  logic              jtag_vld,
  input  logic [CMD_W-1:0]  jtag_cmd,
  input  logic [ADDR_W-1:0] jtag_addr,
  input  logic [DATA_W-1:0] jtag_wdata,
  output logic [DATA_W-1:0] jtag_rdata,
  output logic              jtag_rdy,
  output logic              acq_rst
);
  logic              rst_sync_n;
  logic              busy;
  logic              take;
  logic              fire;
  access_t           grant;
  access_t           held;
  logic              store_en;
  logic [DATA_W-1:0] rd_data;

  logic              frdy_q, frdy_d;
  logic [DATA_W-1:0] fdat_q, fdat_d;
  logic              fdat_en;
  logic              jrdy_q, jrdy_d;
  logic [DATA_W-1:0] jdat_q;
  logic              jdat_en;

  srp_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  srp_arb i_arb (
    .busy       (busy),
    .lock       (jtag_lock),
    .fab_en     (fab_en),
    .fab_we     (fab_we),
    .fab_addr   (fab_addr),
    .fab_wdata  (fab_wdata),
    .jtag_vld   (jtag_vld),
    .jtag_cmd   (jtag_cmd),
    .jtag_addr  (jtag_addr),
    .jtag_wdata (jtag_wdata),
    .take       (take),
    .grant      (grant)
  );

  srp_txn_ctrl #(.LATENCY(LATENCY)) i_txn (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .take  (take),
    .grant (grant),
    .busy  (busy),
    .fire  (fire),
    .held  (held)
  );

  assign store_en = fire && held.we && !held.blocked;

  srp_regfile #(
    .DEPTH     (DEPTH),
    .RSV_LO    (RSV_LO),
    .RSV_HI    (RSV_HI),
    .MODE_ADDR (MODE_ADDR),
    .MODE_LO   (MODE_LO),
    .MODE_W    (MODE_W)
  ) i_regs (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (store_en),
    .addr    (held.addr),
    .wr_data (held.wdata),
    .rd_data (rd_data),
    .acq_rst (acq_rst)
  );

  // fabric response: read data on reads, zero on writes and locked-out requests
  always_comb begin
    frdy_d  = fire && !held.from_jtag;
    fdat_en = frdy_d;
    fdat_d  = (held.we || held.blocked) ? '0 : rd_data;
    jrdy_d  = fire && held.from_jtag;
    jdat_en = jrdy_d && !held.we;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      frdy_q <= 1'b0;
      jrdy_q <= 1'b0;
    end else begin
      frdy_q <= frdy_d;
      jrdy_q <= jrdy_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  fdat_q <= '0;
    else if (fdat_en) fdat_q <= fdat_d;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  jdat_q <= '0;
    else if (jdat_en) jdat_q <= rd_data;
  end

  assign fab_rdy    = frdy_q;
  assign fab_rdata  = fdat_q;
  assign jtag_rdy   = jrdy_q;
  assign jtag_rdata = jdat_q;
endmodule

// File: rtl/srp_chk.sv
module srp_chk
  import srp_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              fab_rdy,
  input logic              jtag_rdy,
  input logic [DATA_W-1:0] fab_rdata,
  input logic [DATA_W-1:0] jtag_rdata,
  input logic              acq_rst
);
  // R4
  fab_rdy_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fab_rdy |=> !fab_rdy);

  // R4
  jtag_rdy_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    jtag_rdy |=> !jtag_rdy);

  // R9
  single_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(fab_rdy && jtag_rdy));

  // R5
  rdy_after_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fab_rdy || jtag_rdy) |-> $past(busy));

  // R2
  fab_data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fab_rdy |-> $stable(fab_rdata));

  // R8
  jtag_data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !jtag_rdy |-> $stable(jtag_rdata));

  // R11
  acq_with_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acq_rst |-> (fab_rdy || jtag_rdy));
endmodule

bind sensor_reg_port srp_chk i_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .busy       (busy),
  .fab_rdy    (fab_rdy),
  .jtag_rdy   (jtag_rdy),
  .fab_rdata  (fab_rdata),
  .jtag_rdata (jtag_rdata),
  .acq_rst    (acq_rst)
);

// File: tb/test_sensor_reg_port.sv
module test_sensor_reg_port;
  logic        clk;
  logic        rst_n;
  logic        fab_en, fab_we;
  logic [6:0]  fab_addr;
  logic [15:0] fab_wdata, fab_rdata;
  logic        fab_rdy;
  logic        jtag_lock, jtag_vld;
  logic [3:0]  jtag_cmd;
  logic [6:0]  jtag_addr;
  logic [15:0] jtag_wdata, jtag_rdata;
  logic        jtag_rdy;
  logic        acq_rst;

  int checks = 0;
  int errors = 0;

  // observations of the last transaction window
  int          f_lat, f_cnt, j_lat, j_cnt, a_lat, a_cnt;
  logic [15:0] f_dat, j_dat;

  sensor_reg_port i_sensor_reg_port (
    .clk(clk), .rst_n(rst_n),
    .fab_en(fab_en), .fab_we(fab_we), .fab_addr(fab_addr), .fab_wdata(fab_wdata),
    .fab_rdata(fab_rdata), .fab_rdy(fab_rdy),
    .jtag_lock(jtag_lock), .jtag_vld(jtag_vld), .jtag_cmd(jtag_cmd),
    .jtag_addr(jtag_addr), .jtag_wdata(jtag_wdata),
    .jtag_rdata(jtag_rdata), .jtag_rdy(jtag_rdy), .acq_rst(acq_rst)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_inputs();
    fab_en = 0; fab_we = 0; fab_addr = '0; fab_wdata = '0;
    jtag_vld = 0; jtag_cmd = '0; jtag_addr = '0; jtag_wdata = '0;
  endtask

  task automatic watch(input int i);
    if (fab_rdy)  begin f_cnt++; if (f_lat < 0) begin f_lat = i - 1; f_dat = fab_rdata; end end
    if (jtag_rdy) begin j_cnt++; if (j_lat < 0) begin j_lat = i - 1; j_dat = jtag_rdata; end end
    if (acq_rst)  begin a_cnt++; if (a_lat < 0) a_lat = i - 1; end
  endtask

  // drive one request set for a single edge, then watch eight cycles
  task automatic txn(input bit fen, input bit fwe, input logic [6:0] fa, input logic [15:0] fd,
                     input bit jv, input logic [3:0] jc, input logic [6:0] ja, input logic [15:0] jd);
    f_lat = -1; f_cnt = 0; j_lat = -1; j_cnt = 0; a_lat = -1; a_cnt = 0;
    @(negedge clk);
    fab_en = fen; fab_we = fwe; fab_addr = fa; fab_wdata = fd;
    jtag_vld = jv; jtag_cmd = jc; jtag_addr = ja; jtag_wdata = jd;
    for (int i = 1; i <= 8; i++) begin
      @(negedge clk);
      if (i == 1) clear_inputs();
      watch(i);
    end
  endtask

  task automatic fab_wr(input logic [6:0] a, input logic [15:0] d);
    txn(1, 1, a, d, 0, 4'd0, '0, '0);
  endtask

  task automatic fab_rd(input logic [6:0] a);
    txn(1, 0, a, '0, 0, 4'd0, '0, '0);
  endtask

  task automatic jtag_op(input logic [3:0] c, input logic [6:0] a, input logic [15:0] d);
    txn(0, 0, '0, '0, 1, c, a, d);
  endtask

  task automatic t_reset();
    chk(fab_rdy == 0 && jtag_rdy == 0, "R1 rdy low", {fab_rdy, jtag_rdy}, 0);
    chk(acq_rst == 0, "R1 acq_rst low", acq_rst, 0);
    chk(fab_rdata == 0 && jtag_rdata == 0, "R1 data zero", fab_rdata, 0);
    fab_rd(7'h10);
    chk(f_dat == 16'h0, "R1 reg reset value", f_dat, 0);
  endtask

  task automatic t_rw_patterns();
    logic [6:0]  al [3] = '{7'h00, 7'h10, 7'h7F};
    logic [15:0] dl [3] = '{16'hA5C3, 16'hFFFF, 16'h0001};
    for (int n = 0; n < 3; n++) begin
      fab_wr(al[n], dl[n]);
      chk(f_lat == 3, "R3 write latency", f_lat, 3);
      chk(f_dat == 0, "R3 write data out zero", f_dat, 0);
    end
    for (int n = 0; n < 3; n++) begin
      fab_rd(al[n]);
      chk(f_lat == 3, "R2 read latency", f_lat, 3);
      chk(f_dat == dl[n], "R2 read data", f_dat, dl[n]);
      chk(f_cnt == 1, "R4 single pulse", f_cnt, 1);
    end
  endtask

  task automatic t_busy_drop();
    f_lat = -1; f_cnt = 0; j_lat = -1; j_cnt = 0; a_lat = -1; a_cnt = 0;
    @(negedge clk);
    fab_en = 1; fab_we = 0; fab_addr = 7'h00;
    for (int i = 1; i <= 8; i++) begin
      @(negedge clk);
      if (i == 1) begin fab_we = 1; fab_addr = 7'h20; fab_wdata = 16'hBEEF; end
      if (i == 4) clear_inputs();
      watch(i);
    end
    chk(f_cnt == 1, "R5 one rdy while pending", f_cnt, 1);
    chk(f_dat == 16'hA5C3, "R5 first read data", f_dat, 16'hA5C3);
    fab_rd(7'h20);
    chk(f_dat == 0, "R5 dropped write not stored", f_dat, 0);
  endtask

  task automatic t_lock();
    @(negedge clk); jtag_lock = 1;
    fab_wr(7'h10, 16'h1234);
    chk(f_lat == 3, "R6 locked rdy latency", f_lat, 3);
    chk(f_dat == 0, "R6 locked data zero", f_dat, 0);
    fab_rd(7'h00);
    chk(f_dat == 0, "R6 locked read zero", f_dat, 0);
    jtag_op(4'd1, 7'h10, '0);
    chk(j_dat == 16'hFFFF, "R6 register untouched", j_dat, 16'hFFFF);
    @(negedge clk); jtag_lock = 0;
    fab_rd(7'h10);
    chk(f_dat == 16'hFFFF, "R6 unlocked read", f_dat, 16'hFFFF);
  endtask

  task automatic t_jtag();
    jtag_op(4'd2, 7'h30, 16'h5A5A);
    chk(j_lat == 3 && j_cnt == 1, "R7 write rdy", j_lat, 3);
    chk(jtag_rdata == 16'hFFFF, "R8 write keeps rdata", jtag_rdata, 16'hFFFF);
    jtag_op(4'd1, 7'h30, '0);
    chk(j_lat == 3 && j_dat == 16'h5A5A, "R7 read", j_dat, 16'h5A5A);
    jtag_op(4'd0, 7'h30, 16'h1111);
    chk(j_cnt == 0 && f_cnt == 0, "R7 nop no rdy", j_cnt, 0);
    jtag_op(4'd5, 7'h30, 16'h2222);
    chk(j_cnt == 0, "R7 undefined code no rdy", j_cnt, 0);
    jtag_op(4'd15, 7'h30, 16'h3333);
    chk(j_cnt == 0, "R7 code 15 no rdy", j_cnt, 0);
    fab_rd(7'h30);
    chk(f_dat == 16'h5A5A, "R7 undefined codes wrote nothing", f_dat, 16'h5A5A);
    chk(jtag_rdata == 16'h5A5A, "R8 rdata held over fabric read", jtag_rdata, 16'h5A5A);
  endtask

  task automatic t_arb();
    txn(1, 0, 7'h30, '0, 1, 4'd2, 7'h31, 16'h7777);
    chk(f_cnt == 1 && j_cnt == 0, "R9 unlocked fabric wins", j_cnt, 0);
    jtag_op(4'd1, 7'h31, '0);
    chk(j_dat == 0, "R9 dropped jtag write", j_dat, 0);
    @(negedge clk); jtag_lock = 1;
    txn(1, 1, 7'h32, 16'h9999, 1, 4'd1, 7'h30, '0);
    chk(j_cnt == 1 && f_cnt == 0, "R9 locked jtag wins", f_cnt, 0);
    chk(j_dat == 16'h5A5A, "R9 jtag read data", j_dat, 16'h5A5A);
    @(negedge clk); jtag_lock = 0;
  endtask

  task automatic t_reserved();
    for (int a = 'h43; a <= 'h47; a++) begin
      fab_wr(7'(a), 16'hC0DE);
      chk(f_cnt == 1, "R10 reserved write rdy", f_cnt, 1);
      fab_rd(7'(a));
      chk(f_dat == 0, "R10 reserved reads zero", f_dat, 0);
    end
    fab_wr(7'h48, 16'h4848);
    fab_rd(7'h48);
    chk(f_dat == 16'h4848, "R10 48h writable", f_dat, 16'h4848);
  endtask

  task automatic t_mode();
    fab_wr(7'h41, 16'h1000);
    chk(a_cnt == 1 && a_lat == 3, "R11 change pulses acq_rst", a_lat, 3);
    fab_wr(7'h41, 16'h1000);
    chk(a_cnt == 0, "R11 same value no pulse", a_cnt, 0);
    fab_wr(7'h41, 16'h1ABC);
    chk(a_cnt == 0, "R11 other bits no pulse", a_cnt, 0);
    jtag_op(4'd2, 7'h41, 16'h2ABC);
    chk(a_cnt == 1 && a_lat == 3, "R11 jtag change pulses", a_cnt, 1);
    fab_wr(7'h40, 16'h3000);
    chk(a_cnt == 0, "R11 other address no pulse", a_cnt, 0);
  endtask

  initial begin
    rst_n = 0; jtag_lock = 0;
    clear_inputs();
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset();
    t_rw_patterns();
    t_busy_drop();
    t_lock();
    t_jtag();
    t_arb();
    t_reserved();
    t_mode();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule